// File: doc/BRIEF.md
# Flow-Through No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Read data is not registered on the way out. The addressed word flows from the array onto the data bus in the same cycle in which the read command was sampled. Write data trails its command by one enabled clock edge. As a result, reads and writes can be issued back to back in any mix, with no idle cycle between them.

Every command is sampled on the rising clock edge. A command either loads a new external address or advances a built-in two-bit burst counter. The counter steps through the four words of an aligned group in interleaved or linear order. Three chip selects gate new accesses.

The data bus is bidirectional and is carried as separate in, out and drive-enable pins, which suits on-chip use. The output-enable pin and the sleep pin act on the drive enable asynchronously. Holding the clock enable low stalls the whole block, so it serves as the only back-pressure mechanism. There is no valid/ready handshake.

Top module: `ntsram_ft`

## Requirements
- R1: After an enabled edge that loads a read (all selects active, `wr_n` high), `dq_oe` is high and `dq_o` carries the addressed word during the cycle that follows. This holds while `oe_n` is low and `sleep` is low.
- R2: A write command's data (`dq_i`) and lane enables are sampled at the next enabled edge. A read of the same word issued on that edge returns the new data at once.
- R3: Lane `l` covers bits `[9l+8:9l]`. Its active-low enable `lane_wr_n[l]` lets that lane be written, and lanes whose enable is high keep their old contents.
- R4: An edge with `clk_en` low captures nothing. Burst state, read output and any pending write are all held, and a pending write then takes its data at the next enabled edge.
- R5: A load with any select inactive (`sel_a_n`, `sel_c_n` active low; `sel_b` active high) deselects the block and leaves `dq_oe` low. `dq_oe` is also low throughout write bursts.
- R6: `advance` low loads the external address and restarts the burst count at 0. `advance` high steps the count and keeps the burst's read or write direction. An advance while deselected is ignored, and the block stays deselected.
- R7: The word offset is the start offset's two low bits XOR the count when `order_linear` is low, and start plus count modulo 4 when it is high. The upper address bits stay fixed and the count wraps after four steps.
- R8: `oe_n` high drops `dq_oe` immediately, without a clock edge.
- R9: `sleep` high drops `dq_oe` immediately. An enabled edge taken during sleep starts no access, ends the current burst and discards a pending write. Array contents survive.
- R10: While `rst_n` is low the block is deselected with no pending write and `dq_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control state |
| clk_en | input | 1 | Clock enable; low suspends the cycle |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low = write, high = read, for a load |
| lane_wr_n | input | LANES (4) | Per-lane write enables, active low |
| advance | input | 1 | High = step burst, low = load address |
| addr | input | AW (8) | Word address |
| order_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| dq_i | input | LANES*LANE_W (36) | Write data from the bus |
| dq_o | output | LANES*LANE_W (36) | Read data onto the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The decisive overlap is a write's data edge coinciding with the address edge of the next read. On that one edge the array must commit the trailing write and also present the newly addressed word. The case is provoked directly, by a write immediately followed by a read of the same word and of a different word. It is also provoked heavily in a long random mix of loads, advances, stalls and deselects. A bench reference model applies the pending write before it evaluates the read, and `dq_o` is compared against it half a cycle after every edge.

// File: rtl/ntsram_ft_pkg.sv
package ntsram_ft_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // word offset inside an aligned group of four
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] cnt,
                                              input logic       linear);
    return linear ? (start + cnt) : (start ^ cnt);
  endfunction

endpackage

// File: rtl/ntsram_burst.sv
module ntsram_burst
  import ntsram_ft_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  input  logic          order_linear,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_inc;

  assign cnt_inc  = cnt_q + 2'd1;
  assign cur_addr = {base_q[AW-1:2], burst_offset(base_q[1:0], cnt_q, order_linear)};

  always_comb begin
    if (load)      nxt_addr = addr_in;
    else if (step) nxt_addr = {base_q[AW-1:2], burst_offset(base_q[1:0], cnt_inc, order_linear)};
    else           nxt_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else if (step) begin
        cnt_q  <= cnt_inc;
      end
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load && step) |=> cnt_q == $past(cnt_q) + 2'd1); // R7
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (take && load) |=> cnt_q == 2'd0); // R6

endmodule

// File: rtl/ntsram_ctrl.sv
module ntsram_ctrl
  import ntsram_ft_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          sleep,
  input  logic          sel_ok,
  input  logic          advance,
  input  logic          wr_n,
  input  logic [AW-1:0] nxt_addr,
  output acc_e          acc,
  output logic          take,
  output logic          load_new,
  output logic          step,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr
);

  acc_e acc_nx;
  logic wr_pend;

  assign take     = clk_en & ~sleep;
  assign load_new = ~advance & sel_ok;
  assign step     = advance & (acc != ACC_IDLE);
  assign wr_fire  = take & wr_pend;

  always_comb begin
    acc_nx = acc;
    if (!advance) acc_nx = !sel_ok ? ACC_IDLE : (wr_n ? ACC_READ : ACC_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= ACC_IDLE;
      wr_pend <= 1'b0;
      wr_addr <= '0;
    end else if (clk_en) begin
      if (sleep) begin
        acc     <= ACC_IDLE;
        wr_pend <= 1'b0;
      end else begin
        acc     <= acc_nx;
        wr_pend <= (acc_nx == ACC_WRITE);
        wr_addr <= nxt_addr;
      end
    end
  end

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(acc) && $stable(wr_pend) && $stable(wr_addr))); // R4
  AST_WRITE_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !advance && sel_ok && !wr_n) |=> wr_pend); // R2
  AST_ADV_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && advance && acc == ACC_IDLE) |=> acc == ACC_IDLE); // R6
  AST_ADV_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && advance && acc != ACC_IDLE) |=> acc == $past(acc)); // R6
  AST_SLEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> (acc == ACC_IDLE && !wr_pend)); // R9

endmodule

// File: rtl/ntsram_array.sv
module ntsram_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        lane_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [WORDS];

    always_ff @(posedge clk) begin
      if (we && !lane_n[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
  end

endmodule

// File: rtl/ntsram_ft.sv
module ntsram_ft
  import ntsram_ft_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    advance,
  input  logic [AW-1:0]           addr,
  input  logic                    order_linear,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);

  localparam int DW = LANES * LANE_W;

  logic          sel_ok;
  acc_e          acc;
  logic          take, load_new, step, wr_fire;
  logic [AW-1:0] cur_addr, nxt_addr, wr_addr;
  logic [DW-1:0] rdata;

  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  ntsram_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
    .sel_ok(sel_ok), .advance(advance), .wr_n(wr_n), .nxt_addr(nxt_addr),
    .acc(acc), .take(take), .load_new(load_new), .step(step),
    .wr_fire(wr_fire), .wr_addr(wr_addr)
  );

  ntsram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .take(take), .load(load_new), .step(step),
    .addr_in(addr), .order_linear(order_linear),
    .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  ntsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(wr_fire), .waddr(wr_addr), .lane_n(lane_wr_n),
    .wdata(dq_i), .raddr(cur_addr), .rdata(rdata)
  );

  // flow-through: no output register between array and bus
  assign dq_o  = rdata;
  assign dq_oe = (acc == ACC_READ) & ~oe_n & ~sleep;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !advance && sel_ok && wr_n) |=> (dq_oe || oe_n || sleep)); // R1
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !advance && !sel_ok) |=> !dq_oe); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !advance && sel_ok && !wr_n) |=> !dq_oe); // R5

endmodule

// File: tb/sim_ntsram_ft.sv
module sim_ntsram_ft;

  localparam int CLK_PERIOD = 10;
  localparam int AW     = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int WORDS  = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clk_en = 1'b1, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic             wr_n = 1'b1, advance = 1'b0, order_linear = 1'b0;
  logic             oe_n = 1'b0, sleep = 1'b0;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    dq_i = '0;
  logic [DW-1:0]    dq_o;
  logic             dq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  logic [DW-1:0] m_mem [WORDS];
  int            m_acc = 0;   // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_wp = 1'b0;
  logic [AW-1:0] m_waddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ntsram_ft #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .advance(advance),
    .addr(addr), .order_linear(order_linear), .oe_n(oe_n), .sleep(sleep),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [AW-1:0] m_eff(input logic lin);
    logic [1:0] off;
    off = lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[AW-1:2], off};
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input bit slp, input bit sa_n, input bit sb, input bit sc_n,
                     input bit adv, input bit wn, input logic [AW-1:0] a,
                     input logic [LANES-1:0] ln, input logic [DW-1:0] d,
                     input bit lin, input bit oen, input string tag);
    bit exp_oe;
    clk_en = en; sleep = slp; sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
    advance = adv; wr_n = wn; addr = a; lane_wr_n = ln; dq_i = d;
    order_linear = lin; oe_n = oen;
    @(posedge clk);
    if (en) begin
      if (slp) begin
        m_acc = 0; m_wp = 1'b0;
      end else begin
        if (m_wp)
          for (int l = 0; l < LANES; l++)
            if (!ln[l]) m_mem[m_waddr][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
        if (!adv) begin
          if (!sa_n && sb && !sc_n) begin
            m_acc = wn ? 1 : 2; m_base = a; m_cnt = 2'd0;
          end else m_acc = 0;
        end else if (m_acc != 0) m_cnt = m_cnt + 2'd1;
        m_wp = (m_acc == 2);
        m_waddr = m_eff(lin);
      end
    end
    @(negedge clk);
    exp_oe = (m_acc == 1) && !oen && !slp;
    chk({tag, " drive"}, 64'(dq_oe), 64'(exp_oe));
    if (exp_oe) chk({tag, " data"}, 64'(dq_o), 64'(m_mem[m_eff(lin)]));
  endtask

  task automatic wr_load(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    cyc(1, 0, 0, 1, 0, 0, 0, a, '0, d, 0, 0, tag);
  endtask
  task automatic rd_load(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit lin, input string tag);
    cyc(1, 0, 0, 1, 0, 0, 1, a, '0, d, lin, 0, tag);
  endtask
  task automatic nop(input logic [DW-1:0] d, input string tag);
    cyc(1, 0, 1, 0, 1, 0, 1, '0, '0, d, 0, 0, tag);
  endtask
  task automatic step_burst(input bit lin, input string tag);
    cyc(1, 0, 1, 0, 1, 1, 0, '0, '0, rnd_word(), lin, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset drive", 64'(dq_oe), 64'd0);
    rst_n = 1'b1;
    nop(rnd_word(), "R10");

    // fill every word, each write's data one edge behind its command
    for (int i = 0; i < WORDS; i++) wr_load(AW'(i), rnd_word(), "R2");
    nop(rnd_word(), "R2");

    // flow-through reads
    rd_load(8'h10, rnd_word(), 0, "R1");
    rd_load(8'hA7, rnd_word(), 0, "R1");
    rd_load(8'hFF, rnd_word(), 0, "R1");

    // write then read the same word on the data edge
    wr_load(8'h33, rnd_word(), "R2");
    rd_load(8'h33, 36'h9_1234_5678, 0, "R2");
    wr_load(8'h40, rnd_word(), "R2");
    rd_load(8'h41, 36'h0_FEED_0001, 0, "R2");
    rd_load(8'h40, rnd_word(), 0, "R2");

    // partial lanes: only lanes 0 and 2 written
    wr_load(8'h05, rnd_word(), "R3");
    cyc(1, 0, 1, 0, 1, 0, 1, '0, 4'b1010, 36'hA_BCDE_F012, 0, 0, "R3");
    rd_load(8'h05, rnd_word(), 0, "R3");

    // suspend: read held, then a pending write held across stalls
    rd_load(8'h21, rnd_word(), 0, "R4");
    cyc(0, 0, 0, 1, 0, 0, 0, 8'h77, '0, rnd_word(), 0, 0, "R4");
    cyc(0, 0, 1, 0, 1, 1, 1, 8'h12, '0, rnd_word(), 0, 0, "R4");
    wr_load(8'h22, rnd_word(), "R4");
    cyc(0, 0, 0, 1, 0, 0, 1, 8'h01, '0, 36'h1_1111_1111, 0, 0, "R4");
    cyc(0, 0, 0, 1, 0, 0, 1, 8'h01, '0, 36'h2_2222_2222, 0, 0, "R4");
    rd_load(8'h22, 36'h3_3333_3333, 0, "R4");

    // deselect by each select, and a quiet bus during writes
    cyc(1, 0, 1, 1, 0, 0, 1, 8'h10, '0, rnd_word(), 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, 1, 8'h10, '0, rnd_word(), 0, 0, "R5");
    cyc(1, 0, 0, 1, 1, 0, 1, 8'h10, '0, rnd_word(), 0, 0, "R5");
    wr_load(8'h60, rnd_word(), "R5");
    step_burst(0, "R5");
    step_burst(0, "R5");
    nop(rnd_word(), "R5");

    // advance keeps direction; advance while deselected stays off
    rd_load(8'h80, rnd_word(), 0, "R6");
    step_burst(0, "R6");
    step_burst(0, "R6");
    nop(rnd_word(), "R6");
    step_burst(0, "R6");
    step_burst(0, "R6");

    // burst orders with wrap
    rd_load(8'h12, rnd_word(), 0, "R7");
    repeat (5) step_burst(0, "R7");
    rd_load(8'h93, rnd_word(), 1, "R7");
    repeat (5) step_burst(1, "R7");

    // asynchronous output enable
    rd_load(8'h44, rnd_word(), 0, "R8");
    #(CLK_PERIOD/4) oe_n = 1'b1;
    #1 chk("R8 async off", 64'(dq_oe), 64'd0);
    oe_n = 1'b0;
    #1 chk("R8 async on", 64'(dq_oe), 64'd1);
    @(negedge clk);

    // sleep: asynchronous quiet, commands ignored, contents kept
    rd_load(8'h45, rnd_word(), 0, "R9");
    #(CLK_PERIOD/4) sleep = 1'b1;
    #1 chk("R9 async off", 64'(dq_oe), 64'd0);
    @(negedge clk);
    wr_load(8'h46, rnd_word(), "R9");
    cyc(1, 1, 0, 1, 0, 0, 0, 8'h45, '0, 36'hF_0000_0000, 0, 0, "R9");
    cyc(1, 1, 0, 1, 0, 0, 1, 8'h45, '0, rnd_word(), 0, 0, "R9");
    cyc(1, 1, 0, 1, 0, 1, 1, 8'h45, '0, rnd_word(), 0, 0, "R9");
    rd_load(8'h45, rnd_word(), 0, "R9");
    rd_load(8'h46, rnd_word(), 0, "R9");

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 100) < 85, ($urandom % 100) < 3,
          ($urandom % 100) < 7, ($urandom % 100) < 93, ($urandom % 100) < 7,
          ($urandom % 100) < 40, ($urandom % 2) == 1, AW'($urandom),
          LANES'($urandom), rnd_word(), ($urandom % 8) == 0,
          ($urandom % 100) < 8, "R1");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule